// File: doc/BRIEF.md
# Bit-Typed Control and Status Register Bank

This block is a small bank of control and status registers behind a byte-wide memory-mapped slave port with address, write strobe, write data, read strobe and read data. Every bit of the bank has its own access behaviour, fixed at build time by five parameter masks:

- read-only bits follow a hardware status input;
- read/write bits hold software settings;
- sticky event bits are set by hardware and cleared by writing zero;
- sticky event bits are set by hardware and cleared by reading them;
- write-one strobe bits produce a single-cycle pulse.

Bits that appear in none of the masks are reserved.

The bank holds `N_REGS` registers of `REG_W` bits. Each register takes `REG_W/8` consecutive byte addresses, and the most significant byte comes first. Hardware raises sticky bits through a per-bit set vector. The read/write bits appear on a flat control output, and the strobe bits appear on a flat pulse output. Read data is registered.

Top module: `csr_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ctl_q`, `pulse_q` and `bus_rdata` are zero, and every stored sticky bit is zero.
- R2: A write to a byte sets each read/write bit of that byte to the matching `bus_wdata` bit. The value shows on `ctl_q` from the cycle after the write and reads back unchanged. `ctl_q` does not change in a cycle without a write. Default layout: register 0 bits 11:0 are read/write.
- R3: A read of a read-only bit returns the `hw_status` bit as it was in the read cycle, and writes have no effect on it. Default layout: register 1 bits 15:0 are read-only.
- R4: A write-zero-clear bit becomes 1 on the edge where its `hw_set` bit is 1 and holds until a write of 0 to it. Writing 1 and reading leave it unchanged. Default layout: register 2 bits 7:0.
- R5: A clear-on-read bit becomes 1 on a `hw_set` edge. A read returns its current value and clears it on the same edge that loads `bus_rdata`. Writes leave it unchanged. Default layout: register 2 bits 15:8.
- R6: Writing 1 to a strobe bit drives its `pulse_q` bit high for exactly the one cycle after the write. Writing 0 leaves it low, and reads of strobe bits return 0. Default layout: register 3 bits 3:0 are strobes, at `pulse_q[51:48]`.
- R7: If a `hw_set` event arrives in the same cycle as a clear of a sticky bit (a zero write or a clearing read), the bit ends up 1.
- R8: Byte address `a` selects register `a / (REG_W/8)`, byte lane `(REG_W/8) - 1 - (a mod (REG_W/8))`, where lane 0 holds the least significant bits. With the defaults, address 0 holds register 0 bits 15:8 and address 1 holds bits 7:0.
- R9: Reserved bits read as 0 and ignore writes. Addresses at or above `N_REGS*REG_W/8` read as 0 and change nothing. Default layout: register 0 bits 15:12 and register 3 bits 15:4 are reserved.
- R10: `bus_rdata` carries the addressed byte in the cycle after `bus_rd` is high, and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data byte |
| hw_status | input | N_REGS*REG_W | Live values for read-only bits |
| hw_set | input | N_REGS*REG_W | Set events for sticky bits |
| ctl_q | output | N_REGS*REG_W | Read/write bit values, zero elsewhere |
| pulse_q | output | N_REGS*REG_W | Single-cycle strobes, zero elsewhere |

## Verification
A wrong byte lane or address decode puts data in the wrong position of `ctl_q` the cycle after the write, and it reads back in the wrong address one cycle after the read strobe. A sticky bit that is stuck, cleared too early or lost to a simultaneous event shows on the next read of its byte. Clear-on-read faults show on the second of two back-to-back reads. A strobe that is wrong or lasts too long shows on `pulse_q` within the two cycles that follow the write.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  typedef enum logic [2:0] {
    K_RSV = 3'd0,
    K_RO  = 3'd1,
    K_RW  = 3'd2,
    K_WZC = 3'd3,
    K_RDC = 3'd4,
    K_STB = 3'd5
  } bit_kind_e;

  // Global byte slot for a byte address: most significant lane at the lowest address.
  function automatic int unsigned byte_slot(input int unsigned addr, input int unsigned bytes);
    return (addr / bytes) * bytes + (bytes - 1 - (addr % bytes));
  endfunction

  // Mask membership to kind; strobe > clear-on-read > write-zero-clear > read/write > read-only.
  function automatic bit_kind_e kind_of(input logic ro, input logic rw, input logic wzc,
                                        input logic rdc, input logic stb);
    if (stb)      return K_STB;
    else if (rdc) return K_RDC;
    else if (wzc) return K_WZC;
    else if (rw)  return K_RW;
    else if (ro)  return K_RO;
    else          return K_RSV;
  endfunction

endpackage

// File: rtl/csr_bank_decode.sv
module csr_bank_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int NBYTES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBYTES-1:0] byte_sel,
  output logic              hit
);

  always_comb begin
    byte_sel = '0;
    hit      = (32'(addr) < NBYTES);
    for (int b = 0; b < NBYTES; b++) begin
      if (hit && (byte_slot(32'(addr), BYTES) == b)) byte_sel[b] = 1'b1;
    end
  end

endmodule

// File: rtl/csr_bank_cell.sv
module csr_bank_cell
  import csr_bank_pkg::*;
#(
  parameter bit_kind_e KIND = K_RSV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic rd_en,
  input  logic wbit,
  input  logic hw_status,
  input  logic hw_set,
  output logic rval,
  output logic ctl,
  output logic pulse
);

  generate
    if (KIND == K_RW) begin : g_rw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= wbit;
      end
      assign rval  = q;
      assign ctl   = q;
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = ^{rd_en, hw_status, hw_set};
    end else if (KIND == K_RO) begin : g_ro
      assign rval  = hw_status;
      assign ctl   = 1'b0;
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, rd_en, wbit, hw_set};
    end else if (KIND == K_WZC) begin : g_wzc
      logic q;
      logic clr;
      assign clr = wr_en & ~wbit;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= hw_set | (q & ~clr);
      end
      assign rval  = q;
      assign ctl   = 1'b0;
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = ^{rd_en, hw_status};
    end else if (KIND == K_RDC) begin : g_rdc
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= hw_set | (q & ~rd_en);
      end
      assign rval  = q;
      assign ctl   = 1'b0;
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = ^{wr_en, wbit, hw_status};
    end else if (KIND == K_STB) begin : g_stb
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= wr_en & wbit;
      end
      assign rval  = 1'b0;
      assign ctl   = 1'b0;
      assign pulse = q;
      logic unused_in;
      assign unused_in = ^{rd_en, hw_status, hw_set};
    end else begin : g_rsv
      assign rval  = 1'b0;
      assign ctl   = 1'b0;
      assign pulse = 1'b0;
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, rd_en, wbit, hw_status, hw_set};
    end
  endgenerate

endmodule

// File: rtl/csr_bank_rdmux.sv
module csr_bank_rdmux #(
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [NBYTES-1:0]     byte_sel,
  input  logic [NBYTES*8-1:0]   rval,
  output logic [7:0]            rdata
);

  logic [7:0] picked;

  always_comb begin
    picked = '0;
    for (int b = 0; b < NBYTES; b++) begin
      picked = picked | (rval[b*8 +: 8] & {8{byte_sel[b]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= picked;
    else         rdata <= '0;
  end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int N_REGS = 4,
  parameter int ADDR_W = 4,
  parameter logic [N_REGS*REG_W-1:0] RO_MASK  = 64'h0000_0000_FFFF_0000,
  parameter logic [N_REGS*REG_W-1:0] RW_MASK  = 64'h0000_0000_0000_0FFF,
  parameter logic [N_REGS*REG_W-1:0] WZC_MASK = 64'h0000_00FF_0000_0000,
  parameter logic [N_REGS*REG_W-1:0] RDC_MASK = 64'h0000_FF00_0000_0000,
  parameter logic [N_REGS*REG_W-1:0] STB_MASK = 64'h000F_0000_0000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata,
  input  logic [N_REGS*REG_W-1:0] hw_status,
  input  logic [N_REGS*REG_W-1:0] hw_set,
  output logic [N_REGS*REG_W-1:0] ctl_q,
  output logic [N_REGS*REG_W-1:0] pulse_q
);

  localparam int BYTES  = REG_W / 8;
  localparam int NBYTES = N_REGS * BYTES;
  localparam int TOT    = N_REGS * REG_W;

  // Named internal events, observed by the bound checker
  logic [NBYTES-1:0] byte_sel;
  logic              addr_hit;
  logic [NBYTES-1:0] wr_sel;
  logic [NBYTES-1:0] rd_sel;
  logic [TOT-1:0]    rval;

  csr_bank_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES), .NBYTES(NBYTES)) u_dec (
    .addr     (bus_addr),
    .byte_sel (byte_sel),
    .hit      (addr_hit)
  );

  assign wr_sel = byte_sel & {NBYTES{bus_wr}};
  assign rd_sel = byte_sel & {NBYTES{bus_rd}};

  generate
    for (genvar g = 0; g < TOT; g++) begin : g_bit
      csr_bank_cell #(
        .KIND(kind_of(RO_MASK[g], RW_MASK[g], WZC_MASK[g], RDC_MASK[g], STB_MASK[g]))
      ) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_sel[g/8]),
        .rd_en     (rd_sel[g/8]),
        .wbit      (bus_wdata[g%8]),
        .hw_status (hw_status[g]),
        .hw_set    (hw_set[g]),
        .rval      (rval[g]),
        .ctl       (ctl_q[g]),
        .pulse     (pulse_q[g])
      );
    end
  endgenerate

  csr_bank_rdmux #(.NBYTES(NBYTES)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .byte_sel (byte_sel),
    .rval     (rval),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int ADDR_W = 4,
  parameter int NBYTES = 8,
  parameter int TOT    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [TOT-1:0]    ctl_q,
  input logic [TOT-1:0]    pulse_q,
  input logic [NBYTES-1:0] byte_sel
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_sel)); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0)); // R10

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (32'(bus_addr) >= NBYTES)) |=> (bus_rdata == '0)); // R9

  AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctl_q)); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (pulse_q == '0)); // R6

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(bus_wr)); // R6

endmodule

bind csr_bank csr_bank_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .TOT(TOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ctl_q     (ctl_q),
  .pulse_q   (pulse_q),
  .byte_sel  (byte_sel)
);

// File: tb/test_csr_bank.sv
module test_csr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [63:0] hw_status = '0;
  logic [63:0] hw_set = '0;
  logic [63:0] ctl_q;
  logic [63:0] pulse_q;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk; // 125 MHz

  csr_bank i_csr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .hw_status (hw_status),
    .hw_set    (hw_set),
    .ctl_q     (ctl_q),
    .pulse_q   (pulse_q)
  );

  // {op[21:20] 1=write 2=read, addr[19:16], wdata[15:8], expected read[7:0]}
  localparam int NVEC = 12;
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1, 4'd0, 8'hFF, 8'h00},  // R2 write reg0 high byte
    {2'd2, 4'd0, 8'h00, 8'h0F},  // R9 bits 15:12 reserved
    {2'd1, 4'd1, 8'h5A, 8'h00},
    {2'd2, 4'd1, 8'h00, 8'h5A},  // R8 address 1 is low byte
    {2'd1, 4'd0, 8'h03, 8'h00},
    {2'd2, 4'd0, 8'h00, 8'h03},  // R2 overwrite clears bits
    {2'd1, 4'd9, 8'hFF, 8'h00},  // R9 unmapped write
    {2'd2, 4'd9, 8'h00, 8'h00},
    {2'd2, 4'd8, 8'h00, 8'h00},
    {2'd1, 4'd6, 8'hFF, 8'h00},  // R9 reserved byte
    {2'd2, 4'd6, 8'h00, 8'h00},
    {2'd2, 4'd7, 8'h00, 8'h00}   // R6 strobe bits read 0
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_set(input logic [63:0] v);
    @(negedge clk);
    hw_set = v;
    @(negedge clk);
    hw_set = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ctl_q in reset", ctl_q, 64'h0);
    check("R1 pulse_q in reset", pulse_q, 64'h0);
    check("R1 rdata in reset", {56'h0, bus_rdata}, 64'h0);
    rst_n = 1'b1;
    do_read(4'd4, rd); check("R1 clear-on-read byte after reset", {56'h0, rd}, 64'h0);
    do_read(4'd5, rd); check("R1 zero-clear byte after reset", {56'h0, rd}, 64'h0);

    // Table walk: R2 R8 R9
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][21:20] == 2'd1) begin
        do_write(VEC[k][19:16], VEC[k][15:8]);
      end else begin
        do_read(VEC[k][19:16], rd);
        check($sformatf("R2 R8 R9 table entry %0d", k), {56'h0, rd}, {56'h0, VEC[k][7:0]});
      end
    end
    check("R2 ctl_q after table", ctl_q, 64'h0000_0000_0000_035A);

    // R10 rdata returns to zero after a read
    do_read(4'd1, rd);
    check("R10 read data", {56'h0, rd}, 64'h5A);
    @(negedge clk);
    check("R10 rdata idle", {56'h0, bus_rdata}, 64'h0);

    // R3 read-only follows status, ignores writes
    hw_status = 64'h0000_0000_BEEF_0000;
    do_read(4'd2, rd); check("R3 status high byte", {56'h0, rd}, 64'hBE);
    do_read(4'd3, rd); check("R3 status low byte", {56'h0, rd}, 64'hEF);
    do_write(4'd2, 8'h00);
    do_read(4'd2, rd); check("R3 write ignored", {56'h0, rd}, 64'hBE);
    hw_status = 64'h0000_0000_1234_0000;
    do_read(4'd3, rd); check("R3 live status", {56'h0, rd}, 64'h34);

    // R4 write-zero-clear
    pulse_set(64'h0000_003C_0000_0000);
    do_read(4'd5, rd); check("R4 set by hardware", {56'h0, rd}, 64'h3C);
    do_write(4'd5, 8'h0F);
    do_read(4'd5, rd); check("R4 zero clears, one keeps", {56'h0, rd}, 64'h0C);
    do_read(4'd5, rd); check("R4 read does not clear", {56'h0, rd}, 64'h0C);
    do_write(4'd5, 8'h00);
    do_read(4'd5, rd); check("R4 cleared", {56'h0, rd}, 64'h00);

    // R7 set wins over zero write
    @(negedge clk);
    hw_set = 64'h0000_0001_0000_0000; bus_addr = 4'd5; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    hw_set = '0; bus_wr = 1'b0;
    do_read(4'd5, rd); check("R7 set beats zero write", {56'h0, rd}, 64'h01);

    // R5 clear-on-read
    pulse_set(64'h0000_A500_0000_0000);
    do_write(4'd4, 8'h00);
    do_read(4'd4, rd); check("R5 first read returns value", {56'h0, rd}, 64'hA5);
    do_read(4'd4, rd); check("R5 second read is zero", {56'h0, rd}, 64'h00);
    do_write(4'd4, 8'hFF);
    do_read(4'd4, rd); check("R5 write ignored", {56'h0, rd}, 64'h00);

    // R7 set wins over clearing read
    pulse_set(64'h0000_8000_0000_0000);
    @(negedge clk);
    bus_addr = 4'd4; bus_rd = 1'b1; hw_set = 64'h0000_0100_0000_0000;
    @(negedge clk);
    bus_rd = 1'b0; hw_set = '0;
    check("R7 read sees old value", {56'h0, bus_rdata}, 64'h80);
    do_read(4'd4, rd); check("R7 set beats read clear", {56'h0, rd}, 64'h01);

    // R6 strobes
    @(negedge clk);
    bus_addr = 4'd7; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 strobe high", pulse_q, 64'h000F_0000_0000_0000);
    @(negedge clk);
    check("R6 strobe one cycle", pulse_q, 64'h0);
    @(negedge clk);
    bus_addr = 4'd7; bus_wdata = 8'h05; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 partial strobe", pulse_q, 64'h0005_0000_0000_0000);
    @(negedge clk);
    bus_addr = 4'd7; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 zero write no strobe", pulse_q, 64'h0);

    // R1 reset mid-run
    check("R2 ctl_q before reset", ctl_q, 64'h0000_0000_0000_035A);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ctl_q cleared by reset", ctl_q, 64'h0);
    rst_n = 1'b1;
    do_read(4'd5, rd); check("R1 sticky cleared by reset", {56'h0, rd}, 64'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule